// File: doc/BRIEF.md
# Isochronous IN Endpoint Transmit Buffer

This block is the transmit half of a single isochronous IN endpoint inside a USB device controller. It holds two packet buffers used as a ping-pong pair. A processor or DMA engine writes bytes into the buffer that is currently filling. That buffer is committed as a packet in one of two ways: when it reaches the maximum packet size, or when software writes the short-packet bit in the control register. The short-packet bit commits whatever the buffer holds, and it may hold no bytes at all.

A simplified token port carries IN tokens. A state machine with the states `TX_IDLE`, `TX_SEND` and `TX_NAK` answers each one. The transitions are:

- `TX_IDLE` to `TX_SEND`: a token arrives while a packet is committed.
- `TX_IDLE` to `TX_NAK`: a token arrives while nothing is committed and the done flag is set.
- `TX_IDLE` stays in `TX_IDLE`: a token arrives while nothing is committed and the done flag is clear.
- `TX_SEND` to `TX_IDLE`: the final byte is accepted.
- `TX_NAK` to `TX_IDLE`: always, after one cycle.

In `TX_SEND` the oldest committed packet leaves one byte per cycle under a valid/ready handshake. When the last byte is accepted, that buffer is freed and a sticky done flag is set. The done flag is cleared by writing one to it, and it raises the interrupt line when the interrupt enable bit is set.

The control/status register is reached through a plain write strobe and a read bus that is always valid.

Write data bits:
- bit 0: writing 1 clears done.
- bit 1: writing 1 requests a short packet.
- bit 2: sets the value of the interrupt enable.

Read data bits:
- bit 0: done.
- bit 1: short request, which always reads 0.
- bit 2: interrupt enable.
- bit 3: service flag.
- bit 4: sticky overrun flag.

Top module: `iso_in_ep`

## Requirements
- R1: After reset, the read bus shows done=0, enable=0, service=1 and overrun=0 (value 0x08), and tx_valid, nak and irq are low.
- R2: Loading MAX_PKT bytes commits the buffer without any short-packet request. A later token sends exactly those bytes in load order.
- R3: Writing 1 to bit 1 commits the filling buffer with its current count. A count of zero yields one transfer with tx_valid, tx_last and tx_zlp all high.
- R4: Read bit 3 (service) is 1 while zero or one packets are committed. It is 0 while both buffers are committed.
- R5: Packets leave in commit order, one byte per accepted cycle. While tx_ready is low, tx_valid, tx_data and tx_last hold. tx_last is high only on the final byte of each packet.
- R6: The cycle after the final byte is accepted, done (read bit 0) is 1 and that buffer counts as free.
- R7: A write with bit 0 set clears done. A write with bit 0 clear leaves done unchanged.
- R8: irq equals done AND the interrupt enable (read bit 2) in every cycle.
- R9: A token arriving with no committed packet while done is 1 drives nak high for exactly the next cycle, and no data is presented.
- R10: A token arriving with no committed packet while done is 0 produces neither nak nor data.
- R11: A set done flag does not hold back a committed packet: the next token sends it.
- R12: Byte writes and short-packet requests made while both buffers are committed are discarded, and overrun (read bit 4) becomes 1 and stays 1.
- R13: Tokens arriving while a packet is being sent are ignored. They produce no nak and no extra packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Byte write strobe into the filling buffer |
| wr_data | input | DW | Byte to store |
| csr_wr | input | 1 | Control register write strobe |
| csr_wdata | input | 3 | bit0 clear done, bit1 short request, bit2 interrupt enable |
| csr_rdata | output | 5 | bit0 done, bit1 zero, bit2 enable, bit3 service, bit4 overrun |
| tok_in | input | 1 | IN token pulse |
| nak | output | 1 | NAK answer, one cycle |
| tx_valid | output | 1 | Transmit byte valid |
| tx_ready | input | 1 | Transmit byte accepted |
| tx_data | output | DW | Transmit byte |
| tx_last | output | 1 | Final byte of the packet |
| tx_zlp | output | 1 | Transfer is a zero-length packet |
| irq | output | 1 | Interrupt request |

## Verification
The bench sweeps every packet length from zero to the full size, both with the interrupt enabled and disabled, and with and without back-pressure. This catches three classes of fault:
- A buffer that commits one byte early or late.
- A short packet that drops its count.
- Data that moves while stalled.

It fills both buffers while done is still set. A design that NAKs on the done flag alone, or that swaps the ping-pong order, sends the wrong packet or none. It also writes into a double-committed store. A design that overwrites a committed buffer, or that lets the short request create a third packet, corrupts the bytes that follow or skips the final NAK. Tokens injected mid-packet catch a state machine that restarts or NAKs while busy.

// File: rtl/iso_in_pkg.sv
package iso_in_pkg;

    typedef enum logic [1:0] {
        TX_IDLE = 2'd0,
        TX_SEND = 2'd1,
        TX_NAK  = 2'd2
    } tx_state_e;

    // write-side field positions
    localparam int WF_CLR_DONE = 0;
    localparam int WF_SHORT    = 1;
    localparam int WF_IEN      = 2;
    localparam int WF_W        = 3;

    // read-side field positions
    localparam int RF_DONE     = 0;
    localparam int RF_SHORT    = 1;
    localparam int RF_IEN      = 2;
    localparam int RF_SVC      = 3;
    localparam int RF_OVR      = 4;
    localparam int RF_W        = 5;

endpackage

// File: rtl/iso_in_pktbuf.sv
module iso_in_pktbuf #(
    parameter int DW      = 8,
    parameter int MAX_PKT = 256,
    parameter int CW      = $clog2(MAX_PKT + 1),
    parameter int IW      = $clog2(MAX_PKT)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_valid,
    input  logic [DW-1:0] wr_data,
    input  logic          short_req,
    input  logic          free_req,
    input  logic [IW-1:0] rd_idx,
    output logic          pend,
    output logic          both_full,
    output logic [CW-1:0] rd_len,
    output logic [DW-1:0] rd_data,
    output logic          drop
);

    logic [DW-1:0] mem [2][MAX_PKT];
    logic [CW-1:0] cnt [2];
    logic [1:0]    full_q;
    logic          wsel;
    logic          rsel;
    logic          write_ok;
    logic          commit;

    assign write_ok = wr_valid && !full_q[wsel];
    assign commit   = (write_ok && (cnt[wsel] == CW'(MAX_PKT - 1)))
                    || (short_req && !full_q[wsel]);
    assign drop     = wr_valid && full_q[wsel];

    for (genvar b = 0; b < 2; b++) begin : g_buf
        logic wr_b;
        logic cm_b;
        logic fr_b;

        assign wr_b = write_ok && (wsel == 1'(b));
        assign cm_b = commit   && (wsel == 1'(b));
        assign fr_b = free_req && (rsel == 1'(b));

        always_ff @(posedge clk) begin
            if (wr_b) begin
                mem[b][cnt[b][IW-1:0]] <= wr_data;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt[b]    <= '0;
                full_q[b] <= 1'b0;
            end else if (fr_b) begin
                cnt[b]    <= '0;
                full_q[b] <= 1'b0;
            end else begin
                if (wr_b) begin
                    cnt[b] <= cnt[b] + CW'(1);
                end
                if (cm_b) begin
                    full_q[b] <= 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wsel <= 1'b0;
            rsel <= 1'b0;
        end else begin
            if (commit) begin
                wsel <= ~wsel;
            end
            if (free_req) begin
                rsel <= ~rsel;
            end
        end
    end

    assign pend      = full_q[rsel];
    assign both_full = &full_q;
    assign rd_len    = cnt[rsel];
    assign rd_data   = mem[rsel][rd_idx];

endmodule

// File: rtl/iso_in_txfsm.sv
module iso_in_txfsm
    import iso_in_pkg::*;
#(
    parameter int DW = 8,
    parameter int CW = 9,
    parameter int IW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tok_in,
    input  logic          pend,
    input  logic          done_flag,
    input  logic [CW-1:0] rd_len,
    input  logic [DW-1:0] rd_data,
    input  logic          tx_ready,
    output logic [IW-1:0] rd_idx,
    output logic          tx_valid,
    output logic [DW-1:0] tx_data,
    output logic          tx_last,
    output logic          tx_zlp,
    output logic          nak,
    output logic          free_req
);

    tx_state_e state;
    tx_state_e state_nx;
    logic      at_last;
    logic      beat;

    assign at_last = (rd_len == '0) || ((CW'(rd_idx) + CW'(1)) == rd_len);
    assign beat    = (state == TX_SEND) && tx_ready;

    always_comb begin
        state_nx = state;
        unique case (state)
            TX_IDLE: begin
                if (tok_in) begin
                    if (pend) begin
                        state_nx = TX_SEND;
                    end else if (done_flag) begin
                        state_nx = TX_NAK;
                    end
                end
            end
            TX_SEND: begin
                if (tx_ready && at_last) begin
                    state_nx = TX_IDLE;
                end
            end
            TX_NAK: begin
                state_nx = TX_IDLE;
            end
            default: begin
                state_nx = TX_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= TX_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_idx <= '0;
        end else if (beat) begin
            rd_idx <= at_last ? '0 : rd_idx + IW'(1);
        end
    end

    always_comb begin
        tx_valid = 1'b0;
        tx_last  = 1'b0;
        tx_zlp   = 1'b0;
        tx_data  = '0;
        nak      = 1'b0;
        free_req = 1'b0;
        unique case (state)
            TX_IDLE: begin
            end
            TX_SEND: begin
                tx_valid = 1'b1;
                tx_last  = at_last;
                tx_zlp   = (rd_len == '0);
                tx_data  = (rd_len == '0) ? '0 : rd_data;
                free_req = tx_ready && at_last;
            end
            TX_NAK: begin
                nak = 1'b1;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/iso_in_csr.sv
module iso_in_csr
    import iso_in_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            csr_wr,
    input  logic [WF_W-1:0] csr_wdata,
    input  logic            done_set,
    input  logic            drop,
    input  logic            svc,
    output logic [RF_W-1:0] csr_rdata,
    output logic            short_req,
    output logic            done_flag,
    output logic            irq
);

    logic ien_q;
    logic ovr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_flag <= 1'b0;
            ien_q     <= 1'b0;
            ovr_q     <= 1'b0;
        end else begin
            if (done_set) begin
                done_flag <= 1'b1;
            end else if (csr_wr && csr_wdata[WF_CLR_DONE]) begin
                done_flag <= 1'b0;
            end
            if (csr_wr) begin
                ien_q <= csr_wdata[WF_IEN];
            end
            if (drop || (short_req && !svc)) begin
                ovr_q <= 1'b1;
            end
        end
    end

    assign short_req = csr_wr && csr_wdata[WF_SHORT];
    assign irq       = done_flag && ien_q;

    always_comb begin
        csr_rdata           = '0;
        csr_rdata[RF_DONE]  = done_flag;
        csr_rdata[RF_SHORT] = 1'b0;
        csr_rdata[RF_IEN]   = ien_q;
        csr_rdata[RF_SVC]   = svc;
        csr_rdata[RF_OVR]   = ovr_q;
    end

endmodule

// File: rtl/iso_in_ep.sv
module iso_in_ep
    import iso_in_pkg::*;
#(
    parameter int DW      = 8,
    parameter int MAX_PKT = 256
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_valid,
    input  logic [DW-1:0]   wr_data,
    input  logic            csr_wr,
    input  logic [WF_W-1:0] csr_wdata,
    output logic [RF_W-1:0] csr_rdata,
    input  logic            tok_in,
    output logic            nak,
    output logic            tx_valid,
    input  logic            tx_ready,
    output logic [DW-1:0]   tx_data,
    output logic            tx_last,
    output logic            tx_zlp,
    output logic            irq
);

    localparam int CW = $clog2(MAX_PKT + 1);
    localparam int IW = $clog2(MAX_PKT);

    logic          short_req;
    logic          free_req;
    logic          pend;
    logic          both_full;
    logic          drop;
    logic          done_flag;
    logic [CW-1:0] rd_len;
    logic [DW-1:0] rd_data;
    logic [IW-1:0] rd_idx;

    iso_in_pktbuf #(.DW(DW), .MAX_PKT(MAX_PKT), .CW(CW), .IW(IW)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_valid  (wr_valid),
        .wr_data   (wr_data),
        .short_req (short_req),
        .free_req  (free_req),
        .rd_idx    (rd_idx),
        .pend      (pend),
        .both_full (both_full),
        .rd_len    (rd_len),
        .rd_data   (rd_data),
        .drop      (drop)
    );

    iso_in_txfsm #(.DW(DW), .CW(CW), .IW(IW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tok_in    (tok_in),
        .pend      (pend),
        .done_flag (done_flag),
        .rd_len    (rd_len),
        .rd_data   (rd_data),
        .tx_ready  (tx_ready),
        .rd_idx    (rd_idx),
        .tx_valid  (tx_valid),
        .tx_data   (tx_data),
        .tx_last   (tx_last),
        .tx_zlp    (tx_zlp),
        .nak       (nak),
        .free_req  (free_req)
    );

    iso_in_csr u_csr (
        .clk       (clk),
        .rst_n     (rst_n),
        .csr_wr    (csr_wr),
        .csr_wdata (csr_wdata),
        .done_set  (free_req),
        .drop      (drop),
        .svc       (!both_full),
        .csr_rdata (csr_rdata),
        .short_req (short_req),
        .done_flag (done_flag),
        .irq       (irq)
    );

endmodule

// File: rtl/iso_in_ep_chk.sv
module iso_in_ep_chk
    import iso_in_pkg::*;
#(
    parameter int DW = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            csr_wr,
    input logic [WF_W-1:0] csr_wdata,
    input logic [RF_W-1:0] csr_rdata,
    input logic            tok_in,
    input logic            nak,
    input logic            tx_valid,
    input logic            tx_ready,
    input logic [DW-1:0]   tx_data,
    input logic            tx_last,
    input logic            irq
);

    assert_irq_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (csr_rdata[RF_DONE] && csr_rdata[RF_IEN]));

    assert_stall_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

    assert_done_after_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready && tx_last) |=> csr_rdata[RF_DONE]);

    assert_nak_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        nak |=> !nak);

    assert_nak_no_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
        nak |-> !tx_valid);

    assert_w0_keeps_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_wr && !csr_wdata[WF_CLR_DONE] && csr_rdata[RF_DONE]) |=> csr_rdata[RF_DONE]);

    assert_overrun_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
        csr_rdata[RF_OVR] |=> csr_rdata[RF_OVR]);

    assert_busy_token_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !(tx_ready && tx_last) && tok_in) |=> (tx_valid && !nak));

endmodule

bind iso_in_ep iso_in_ep_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .csr_wr    (csr_wr),
    .csr_wdata (csr_wdata),
    .csr_rdata (csr_rdata),
    .tok_in    (tok_in),
    .nak       (nak),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .tx_data   (tx_data),
    .tx_last   (tx_last),
    .irq       (irq)
);

// File: tb/iso_in_ep_test.sv
module iso_in_ep_test;

    localparam int MAXP = 4;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       wr_valid;
    logic [7:0] wr_data;
    logic       csr_wr;
    logic [2:0] csr_wdata;
    logic [4:0] csr_rdata;
    logic       tok_in;
    logic       nak;
    logic       tx_valid;
    logic       tx_ready;
    logic [7:0] tx_data;
    logic       tx_last;
    logic       tx_zlp;
    logic       irq;

    int n_chk = 0;
    int n_bad = 0;
    bit ien   = 1'b0;
    bit ended = 1'b0;

    always #5 clk = ~clk;

    iso_in_ep #(.DW(8), .MAX_PKT(MAXP)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_valid  (wr_valid),
        .wr_data   (wr_data),
        .csr_wr    (csr_wr),
        .csr_wdata (csr_wdata),
        .csr_rdata (csr_rdata),
        .tok_in    (tok_in),
        .nak       (nak),
        .tx_valid  (tx_valid),
        .tx_ready  (tx_ready),
        .tx_data   (tx_data),
        .tx_last   (tx_last),
        .tx_zlp    (tx_zlp),
        .irq       (irq)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int p, input int i);
        return 8'((p * 37 + i * 11 + 3) & 255);
    endfunction

    task automatic cw(input bit clr, input bit shrt);
        csr_wr    = 1'b1;
        csr_wdata = {ien, shrt, clr};
        tick();
        csr_wr    = 1'b0;
        csr_wdata = '0;
    endtask

    task automatic load(input int p, input int len);
        for (int i = 0; i < len; i++) begin
            wr_valid = 1'b1;
            wr_data  = pat(p, i);
            tick();
        end
        wr_valid = 1'b0;
        if (len < MAXP) cw(1'b0, 1'b1);
    endtask

    task automatic token();
        tok_in = 1'b1;
        tick();
        tok_in = 1'b0;
    endtask

    task automatic send(input int p, input int len, input bit stall, input bit poke, input string req);
        int n;
        bit fin;
        bit rdy;
        n   = 0;
        fin = 1'b0;
        token();
        for (int c = 0; c < 40 && !fin; c++) begin
            if (!tx_valid) begin
                chk(1'b0, req, 0, 1);
                break;
            end
            rdy = !(stall && (c % 2 == 0));
            if (len == 0) begin
                chk(tx_zlp && tx_last, "R3", int'({tx_zlp, tx_last}), 3);
            end else begin
                chk(tx_data == pat(p, n), req, int'(tx_data), int'(pat(p, n)));
                chk(tx_last == (n == len - 1), "R5", int'(tx_last), int'(n == len - 1));
            end
            tx_ready = rdy;
            tok_in   = poke && (c == 1);
            tick();
            tx_ready = 1'b0;
            tok_in   = 1'b0;
            chk(!nak, "R13", int'(nak), 0);
            if (rdy) begin
                if (len == 0 || n == len - 1) fin = 1'b1;
                n++;
            end
        end
        chk(fin, req, int'(fin), 1);
        chk(!tx_valid, "R13", int'(tx_valid), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!ended) begin
            ended = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int pid;
        rst_n     = 1'b0;
        wr_valid  = 1'b0;
        wr_data   = '0;
        csr_wr    = 1'b0;
        csr_wdata = '0;
        tok_in    = 1'b0;
        tx_ready  = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk(csr_rdata == 5'h08, "R1", int'(csr_rdata), 8);
        chk(!tx_valid && !nak && !irq, "R1", int'({tx_valid, nak, irq}), 0);

        pid = 0;
        for (int e = 0; e < 2; e++) begin
            ien = bit'(e);
            cw(1'b0, 1'b0);
            for (int s = 0; s < 2; s++) begin
                for (int len = 0; len <= MAXP; len++) begin
                    load(pid, len);
                    chk(csr_rdata[3] == 1'b1, "R4", int'(csr_rdata[3]), 1);
                    chk(csr_rdata[0] == 1'b0, "R7", int'(csr_rdata[0]), 0);
                    send(pid, len, bit'(s), bit'(s) && len == MAXP, (len == MAXP) ? "R2" : "R3");
                    chk(csr_rdata[0] == 1'b1, "R6", int'(csr_rdata[0]), 1);
                    chk(csr_rdata[3] == 1'b1, "R6", int'(csr_rdata[3]), 1);
                    chk(irq == ien, "R8", int'(irq), int'(ien));
                    cw(1'b0, 1'b0);
                    chk(csr_rdata[0] == 1'b1, "R7", int'(csr_rdata[0]), 1);
                    cw(1'b1, 1'b0);
                    chk(csr_rdata[0] == 1'b0, "R7", int'(csr_rdata[0]), 0);
                    chk(irq == 1'b0, "R8", int'(irq), 0);
                    pid++;
                end
            end
        end

        // R10: nothing committed, done clear
        token();
        chk(!nak && !tx_valid, "R10", int'({nak, tx_valid}), 0);
        tick();
        chk(!nak && !tx_valid, "R10", int'({nak, tx_valid}), 0);

        // R9: nothing committed, done set
        load(pid, 1);
        send(pid, 1, 1'b0, 1'b0, "R9");
        pid++;
        token();
        chk(nak && !tx_valid, "R9", int'({nak, tx_valid}), 2);
        tick();
        chk(!nak, "R9", int'(nak), 0);

        // R11 and R5 ordering with done still set
        load(pid, 2);
        load(pid + 1, MAXP);
        chk(csr_rdata[3] == 1'b0, "R4", int'(csr_rdata[3]), 0);
        send(pid, 2, 1'b0, 1'b0, "R11");
        chk(csr_rdata[3] == 1'b1, "R4", int'(csr_rdata[3]), 1);
        send(pid + 1, MAXP, 1'b1, 1'b0, "R5");
        pid += 2;

        // R12 overrun
        chk(csr_rdata[4] == 1'b0, "R12", int'(csr_rdata[4]), 0);
        load(pid, 1);
        load(pid + 1, MAXP);
        for (int i = 0; i < 3; i++) begin
            wr_valid = 1'b1;
            wr_data  = 8'hEE;
            tick();
        end
        wr_valid = 1'b0;
        cw(1'b0, 1'b1);
        chk(csr_rdata[4] == 1'b1, "R12", int'(csr_rdata[4]), 1);
        chk(csr_rdata[3] == 1'b0, "R12", int'(csr_rdata[3]), 0);
        send(pid, 1, 1'b0, 1'b0, "R12");
        send(pid + 1, MAXP, 1'b0, 1'b0, "R12");
        token();
        chk(nak && !tx_valid, "R12", int'({nak, tx_valid}), 2);
        tick();
        chk(csr_rdata[4] == 1'b1, "R12", int'(csr_rdata[4]), 1);

        if (!ended) begin
            ended = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule